// File: doc/BRIEF.md
# Configurable Gate-Grid Evaluator

The block evaluates a feed-forward grid of configurable logic cells. The grid has ROWS rows and COLS columns. Each cell is set up through a write port with a function code, an input count and up to four source node identifiers. Each of NUM_OUT outputs is set up to show the value of one chosen cell. A primary input vector is captured when its valid strobe is high. The whole grid settles combinationally from the captured vector, and the selected cell values are registered as the result.

Nodes are numbered as follows. Identifiers 0 to NUM_IN-1 are the primary inputs. Cells follow in column-major order: the cell in column c and row r has identifier NUM_IN + c*ROWS + r. A cell may read any primary input. It may also read any cell in the LEVEL_BACK columns immediately to its left. The block checks every cell configuration when it is written. A configuration that breaks these rules makes that cell drive 0 and raises an error flag that stays set.

Top module: `gg_grid_eval`

## Requirements
- R1: After reset, outValid, outVec and configError are all 0. Every cell holds function code 0, and every output selects node 0.
- R2: Function code 7 is AND, code 6 is OR and code 9 is XOR. Each reduces across source slots 0 to arity-1.
- R3: Code 8 (NOT) drives the inverse of slot 0. Code 10 (MUX) drives slot 1 when slot 2 is 1, and slot 0 otherwise. Any slot at index arity or above reads as 0.
- R4: A cell with any other function code drives 0. A cell with arity 0 also drives 0.
- R5: A cell configuration write with cfgWrId = NUM_IN + c*ROWS + r sets the cell in column c and row r. Each source slot i sits at cfgWrSrc[i*IDW +: IDW].
- R6: A used source slot (index below arity) is legal if it names a primary input, or a cell in columns c-LEVEL_BACK to c-1. An arity above 4 is illegal. An illegal write makes that cell drive 0 and sets configError at the write edge.
- R7: configError stays 1 until reset, even if the faulty cell is later rewritten legally. The rewritten cell works again.
- R8: outVec[j] shows the cell named by output select j. An output select that names a primary input, or an identifier beyond the last cell, gives 0.
- R9: A vector presented with inValid is captured at that clock edge. outVec and a one-cycle outValid pulse follow at the next edge. Between results, outVec holds its value while inVec changes.
- R10: A cell configuration write whose identifier is not a cell changes nothing and raises no error.
- R11: Source slots at index arity or above are not checked for legality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Write strobe for a cell configuration |
| cfgWrId | input | IDW | Node identifier of the cell to write |
| cfgWrFunc | input | 4 | Function code |
| cfgWrArity | input | 3 | Number of used source slots |
| cfgWrSrc | input | 4*IDW | Four source node identifiers, slot i at bits i*IDW |
| selWrEn | input | 1 | Write strobe for an output select |
| selWrIdx | input | OSW | Index of the output to set up |
| selWrId | input | IDW | Cell identifier that the output shows |
| inValid | input | 1 | Captures inVec at this edge |
| inVec | input | NUM_IN | Primary input vector |
| outValid | output | 1 | One-cycle pulse marking a new result |
| outVec | output | NUM_OUT | Registered selected cell values |
| configError | output | 1 | Sticky flag for an illegal cell configuration |

## Verification
A vector strobed with inValid is captured at edge A. Its result and the outValid pulse appear at edge A+1. The scoreboard stamps each expected result with the cycle count at the falling edge where the stimulus is driven. The monitor samples at falling edges only, and requires that a result arrives exactly two counts after its stamp. The monitor also flags any pulse that has no expected item. configError is updated at the edge that accepts the write, so the bench reads it at the falling edge that follows. An output held between results is read over several falling edges after inVec has been changed without a strobe.

// File: rtl/gg_pkg.sv
package gg_pkg;
  localparam int MAX_FANIN = 4;
  localparam int FUNC_W = 4;
  localparam int ARITY_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_OR  = 4'd6,
    FN_AND = 4'd7,
    FN_NOT = 4'd8,
    FN_XOR = 4'd9,
    FN_MUX = 4'd10
  } func_e;

  typedef struct packed {
    logic loadIn;
    logic launch;
  } strobe_t;
endpackage

// File: rtl/gg_cell.sv
module gg_cell
  import gg_pkg::*;
(
  input  logic [FUNC_W-1:0]    func,
  input  logic [ARITY_W-1:0]   arity,
  input  logic                 ok,
  input  logic [MAX_FANIN-1:0] pins,
  output logic                 y
);
  logic [MAX_FANIN-1:0] used;
  logic [MAX_FANIN-1:0] live;

  always_comb begin
    for (int i = 0; i < MAX_FANIN; i++) used[i] = (ARITY_W'(i) < arity);
    live = pins & used;
    y = 1'b0;
    if (ok && arity != '0) begin
      case (func)
        FN_AND:  y = &(live | ~used);
        FN_OR:   y = |live;
        FN_XOR:  y = ^live;
        FN_NOT:  y = ~live[0];
        FN_MUX:  y = live[2] ? live[1] : live[0];
        default: y = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gg_ctrl.sv
module gg_ctrl
  import gg_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int NUM_OUT = 2,
  parameter int ROWS = 2,
  parameter int COLS = 4,
  parameter int LEVEL_BACK = 2,
  localparam int CELLS = ROWS * COLS,
  localparam int NODES = NUM_IN + CELLS,
  localparam int IDW = $clog2(NODES),
  localparam int OSW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   cfgWrEn,
  input  logic [IDW-1:0]                         cfgWrId,
  input  logic [FUNC_W-1:0]                      cfgWrFunc,
  input  logic [ARITY_W-1:0]                     cfgWrArity,
  input  logic [MAX_FANIN*IDW-1:0]               cfgWrSrc,
  input  logic                                   selWrEn,
  input  logic [OSW-1:0]                         selWrIdx,
  input  logic [IDW-1:0]                         selWrId,
  input  logic                                   inValid,
  output logic [CELLS-1:0][FUNC_W-1:0]           cellFunc,
  output logic [CELLS-1:0][ARITY_W-1:0]          cellArity,
  output logic [CELLS-1:0][MAX_FANIN-1:0][IDW-1:0] cellSrc,
  output logic [CELLS-1:0]                       cellOk,
  output logic [NUM_OUT-1:0][IDW-1:0]            outSel,
  output strobe_t                                strobe,
  output logic                                   outValid,
  output logic                                   configError
);
  logic wrHit;
  logic wrOk;
  int   wrCell;
  logic launchPend;

  function automatic logic srcLegal(input int cellIdx, input logic [IDW-1:0] src);
    int myCol;
    int srcCol;
    myCol = cellIdx / ROWS;
    if (int'(src) < NUM_IN) return 1'b1;
    if (int'(src) >= NODES) return 1'b0;
    srcCol = (int'(src) - NUM_IN) / ROWS;
    return (srcCol < myCol) && (srcCol >= myCol - LEVEL_BACK);
  endfunction

  always_comb begin
    wrCell = int'(cfgWrId) - NUM_IN;
    wrHit = cfgWrEn && (int'(cfgWrId) >= NUM_IN) && (int'(cfgWrId) < NODES);
    wrOk = (cfgWrArity <= ARITY_W'(MAX_FANIN));
    for (int i = 0; i < MAX_FANIN; i++) begin
      if ((ARITY_W'(i) < cfgWrArity) && !srcLegal(wrCell, cfgWrSrc[i*IDW +: IDW]))
        wrOk = 1'b0;
    end
  end

  for (genvar k = 0; k < CELLS; k++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cellFunc[k]  <= '0;
        cellArity[k] <= '0;
        cellSrc[k]   <= '0;
        cellOk[k]    <= 1'b1;
      end else if (wrHit && wrCell == k) begin
        cellFunc[k]  <= cfgWrFunc;
        cellArity[k] <= cfgWrArity;
        cellSrc[k]   <= cfgWrSrc;
        cellOk[k]    <= wrOk;
      end
    end
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) outSel[j] <= '0;
      else if (selWrEn && int'(selWrIdx) == j) outSel[j] <= selWrId;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      configError <= 1'b0;
      launchPend  <= 1'b0;
      outValid    <= 1'b0;
    end else begin
      if (wrHit && !wrOk) configError <= 1'b1;
      launchPend <= inValid;
      outValid   <= launchPend;
    end
  end

  always_comb begin
    strobe.loadIn = inValid;
    strobe.launch = launchPend;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) configError |=> configError); // R7
  AST_BAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rstN) (wrHit && !wrOk) |=> configError); // R6
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rstN) inValid |-> ##2 outValid); // R9
  AST_RESULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN) outValid |-> $past(inValid, 2)); // R9
endmodule

// File: rtl/gg_datapath.sv
module gg_datapath
  import gg_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int NUM_OUT = 2,
  parameter int ROWS = 2,
  parameter int COLS = 4,
  localparam int CELLS = ROWS * COLS,
  localparam int NODES = NUM_IN + CELLS,
  localparam int IDW = $clog2(NODES)
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  strobe_t                                  strobe,
  input  logic [NUM_IN-1:0]                        inVec,
  input  logic [CELLS-1:0][FUNC_W-1:0]             cellFunc,
  input  logic [CELLS-1:0][ARITY_W-1:0]            cellArity,
  input  logic [CELLS-1:0][MAX_FANIN-1:0][IDW-1:0] cellSrc,
  input  logic [CELLS-1:0]                         cellOk,
  input  logic [NUM_OUT-1:0][IDW-1:0]              outSel,
  output logic [NUM_OUT-1:0]                       outVec
);
  logic [NUM_IN-1:0] inReg;
  logic [NODES-1:0]  allNodes;
  logic [NUM_OUT-1:0] pick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inReg <= '0;
    else if (strobe.loadIn) inReg <= inVec;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [NODES-1:0] seenIn;
    logic [NODES-1:0] seenOut;
    logic [ROWS-1:0]  colY;

    if (c == 0) begin : g_first
      assign seenIn = NODES'(inReg);
    end else begin : g_next
      assign seenIn = g_col[c-1].seenOut;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int K = c * ROWS + r;
      logic [MAX_FANIN-1:0] pins;
      logic cellY;

      always_comb begin
        for (int i = 0; i < MAX_FANIN; i++)
          pins[i] = (int'(cellSrc[K][i]) < NODES) ? seenIn[cellSrc[K][i]] : 1'b0;
      end

      gg_cell u_cell (
        .func (cellFunc[K]),
        .arity(cellArity[K]),
        .ok   (cellOk[K]),
        .pins (pins),
        .y    (cellY)
      );

      assign colY[r] = cellY;

      AST_BAD_CELL_ZERO: assert property (@(posedge clk) disable iff (!rstN) !cellOk[K] |-> !cellY); // R6
    end

    assign seenOut = seenIn | (NODES'(colY) << (NUM_IN + c * ROWS));
  end

  assign allNodes = g_col[COLS-1].seenOut;

  always_comb begin
    for (int j = 0; j < NUM_OUT; j++)
      pick[j] = (int'(outSel[j]) >= NUM_IN && int'(outSel[j]) < NODES) ? allNodes[outSel[j]] : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outVec <= '0;
    else if (strobe.launch) outVec <= pick;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strobe.launch |=> $stable(outVec)); // R9
endmodule

// File: rtl/gg_grid_eval.sv
module gg_grid_eval
  import gg_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int NUM_OUT = 2,
  parameter int ROWS = 2,
  parameter int COLS = 4,
  parameter int LEVEL_BACK = 2,
  localparam int CELLS = ROWS * COLS,
  localparam int IDW = $clog2(NUM_IN + CELLS),
  localparam int OSW = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [IDW-1:0]           cfgWrId,
  input  logic [3:0]               cfgWrFunc,
  input  logic [2:0]               cfgWrArity,
  input  logic [4*IDW-1:0]         cfgWrSrc,
  input  logic                     selWrEn,
  input  logic [OSW-1:0]           selWrIdx,
  input  logic [IDW-1:0]           selWrId,
  input  logic                     inValid,
  input  logic [NUM_IN-1:0]        inVec,
  output logic                     outValid,
  output logic [NUM_OUT-1:0]       outVec,
  output logic                     configError
);
  logic [CELLS-1:0][FUNC_W-1:0]             cellFunc;
  logic [CELLS-1:0][ARITY_W-1:0]            cellArity;
  logic [CELLS-1:0][MAX_FANIN-1:0][IDW-1:0] cellSrc;
  logic [CELLS-1:0]                         cellOk;
  logic [NUM_OUT-1:0][IDW-1:0]              outSel;
  strobe_t                                  strobe;

  gg_ctrl #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ROWS(ROWS), .COLS(COLS), .LEVEL_BACK(LEVEL_BACK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrId(cfgWrId), .cfgWrFunc(cfgWrFunc),
    .cfgWrArity(cfgWrArity), .cfgWrSrc(cfgWrSrc),
    .selWrEn(selWrEn), .selWrIdx(selWrIdx), .selWrId(selWrId),
    .inValid(inValid),
    .cellFunc(cellFunc), .cellArity(cellArity), .cellSrc(cellSrc), .cellOk(cellOk),
    .outSel(outSel), .strobe(strobe), .outValid(outValid), .configError(configError)
  );

  gg_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .ROWS(ROWS), .COLS(COLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inVec(inVec),
    .cellFunc(cellFunc), .cellArity(cellArity), .cellSrc(cellSrc), .cellOk(cellOk),
    .outSel(outSel), .outVec(outVec)
  );
endmodule

// File: tb/sim_gg_grid_eval.sv
`timescale 1ns/1ps
module sim_gg_grid_eval;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int IDW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [IDW-1:0] cfgWrId = '0;
  logic [3:0] cfgWrFunc = '0;
  logic [2:0] cfgWrArity = '0;
  logic [4*IDW-1:0] cfgWrSrc = '0;
  logic selWrEn = 1'b0;
  logic [0:0] selWrIdx = '0;
  logic [IDW-1:0] selWrId = '0;
  logic inValid = 1'b0;
  logic [NI-1:0] inVec = '0;
  logic outValid;
  logic [NO-1:0] outVec;
  logic configError;

  gg_grid_eval #(.NUM_IN(NI), .NUM_OUT(NO), .ROWS(2), .COLS(4), .LEVEL_BACK(2)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrId(cfgWrId), .cfgWrFunc(cfgWrFunc),
    .cfgWrArity(cfgWrArity), .cfgWrSrc(cfgWrSrc), .selWrEn(selWrEn), .selWrIdx(selWrIdx),
    .selWrId(selWrId), .inValid(inValid), .inVec(inVec), .outValid(outValid),
    .outVec(outVec), .configError(configError)
  );

  typedef struct {
    logic [NO-1:0] data;
    int            stamp;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected outValid", int'(outVec), 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(outVec == e.data, e.tag, int'(outVec), int'(e.data));
        check((cyc - e.stamp) == 2, "R9 result latency", cyc - e.stamp, 2);
      end
    end
  end

  task automatic writeCell(input int id, input int fn, input int ar,
                           input int s0, input int s1, input int s2, input int s3);
    @(negedge clk);
    cfgWrEn = 1'b1;
    cfgWrId = IDW'(id);
    cfgWrFunc = 4'(fn);
    cfgWrArity = 3'(ar);
    cfgWrSrc = {IDW'(s3), IDW'(s2), IDW'(s1), IDW'(s0)};
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic writeOut(input int idx, input int id);
    @(negedge clk);
    selWrEn = 1'b1;
    selWrIdx = 1'(idx);
    selWrId = IDW'(id);
    @(negedge clk);
    selWrEn = 1'b0;
  endtask

  task automatic applyVec(input logic [NI-1:0] v, input logic [NO-1:0] exp, input string tag);
    @(negedge clk);
    inVec = v;
    inValid = 1'b1;
    expQ.push_back('{exp, cyc, tag});
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [NO-1:0] held;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && outVec == '0 && configError == 1'b0, "R1 reset state",
          int'({outValid, outVec, configError}), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: the reset configuration gives 0 on every output
    applyVec(3'b111, 2'b00, "R1 reset configuration output");
    drain();

    // R2 R5 R8 R11: XOR, AND, OR, four-input AND, outputs select cells 5 and 7
    writeCell(3, 9, 3, 0, 1, 2, 0);
    writeCell(4, 7, 2, 0, 1, 8, 8);
    writeCell(5, 6, 2, 3, 4, 0, 0);
    writeCell(7, 7, 4, 3, 5, 2, 4);
    writeOut(0, 5);
    writeOut(1, 7);
    @(negedge clk);
    check(configError == 1'b0, "R11 unused slots not checked", int'(configError), 0);
    for (int v = 0; v < 8; v++) begin
      logic x0, x1, x2, o3, o4, o5, o7;
      x0 = v[0]; x1 = v[1]; x2 = v[2];
      o3 = x0 ^ x1 ^ x2;
      o4 = x0 & x1;
      o5 = o3 | o4;
      o7 = o3 & o5 & x2 & o4;
      applyVec(3'(v), {o7, o5}, "R2 R5 R8 reduction network");
    end
    drain();

    // R9: output holds while inVec changes without a strobe
    held = outVec;
    inVec = 3'b010;
    repeat (3) begin
      @(negedge clk);
      check(outVec == held && outValid == 1'b0, "R9 output hold", int'({outValid, outVec}), int'(held));
    end

    // R3: NOT and three-input MUX
    writeCell(3, 8, 1, 1, 0, 0, 0);
    writeCell(4, 10, 3, 0, 1, 2, 0);
    writeOut(0, 4);
    writeOut(1, 3);
    for (int v = 0; v < 8; v++) begin
      logic x0, x1, x2;
      x0 = v[0]; x1 = v[1]; x2 = v[2];
      applyVec(3'(v), {~x1, (x2 ? x1 : x0)}, "R3 NOT and MUX");
    end
    drain();

    // R3 R4: MUX with arity 2 sees select 0; unknown code drives 0
    writeCell(6, 10, 2, 0, 1, 2, 0);
    writeCell(8, 12, 2, 0, 1, 0, 0);
    writeOut(0, 6);
    writeOut(1, 8);
    for (int v = 4; v < 8; v++) begin
      logic x0;
      x0 = v[0];
      applyVec(3'(v), {1'b0, x0}, "R3 R4 masked select and unknown code");
    end
    drain();

    // R4 R8: arity 0 cell, primary-input select, out-of-range select
    writeCell(5, 7, 0, 0, 0, 0, 0);
    writeOut(0, 2);
    writeOut(1, 5);
    applyVec(3'b111, 2'b00, "R4 R8 arity zero and primary select");
    writeOut(0, 13);
    applyVec(3'b111, 2'b00, "R8 select beyond last cell");
    drain();

    // R10: writes to identifiers that are not cells
    writeCell(1, 7, 2, 9, 10, 0, 0);
    writeCell(15, 7, 2, 9, 10, 0, 0);
    @(negedge clk);
    check(configError == 1'b0, "R10 non-cell write ignored", int'(configError), 0);
    writeOut(0, 4);
    writeOut(1, 3);
    applyVec(3'b101, 2'b10, "R10 cells unchanged after non-cell write");
    drain();

    // R6: cell 9 (column 3) reads cell 3 (column 0), outside a window of 2
    writeCell(9, 6, 2, 3, 0, 0, 0);
    check(configError == 1'b1, "R6 level-back violation flagged", int'(configError), 1);
    writeOut(1, 9);
    applyVec(3'b111, 2'b01, "R6 illegal cell drives 0");
    drain();

    // R7: legal rewrite restores cell, flag stays
    writeCell(9, 6, 2, 0, 1, 0, 0);
    @(negedge clk);
    check(configError == 1'b1, "R7 error sticky", int'(configError), 1);
    applyVec(3'b001, 2'b11, "R7 rewritten cell works");
    drain();

    // R6: forward reference from column 1 to column 2
    writeCell(5, 6, 2, 7, 0, 0, 0);
    writeOut(1, 5);
    applyVec(3'b111, 2'b01, "R6 forward source drives 0");
    drain();

    // R1 R7: reset clears the flag and outputs
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(configError == 1'b0 && outVec == '0 && outValid == 1'b0, "R1 R7 cleared by reset",
          int'({outValid, outVec, configError}), 0);
    rstN = 1'b1;

    // R6: arity above 4 is illegal
    writeCell(10, 7, 5, 0, 1, 2, 0);
    check(configError == 1'b1, "R6 arity above four flagged", int'(configError), 1);
    writeOut(0, 10);
    applyVec(3'b111, 2'b00, "R6 over-arity cell drives 0");
    drain();

    check(expQ.size() == 0, "R9 every result delivered", expQ.size(), 0);
    finishRun();
  end
endmodule